// File: doc/BRIEF.md
# Interrupt and Reset Front End

This block sits between the raw control pins of a processor and its execution core. It takes four asynchronous inputs: a reset request, a maskable interrupt request, a non-maskable interrupt request and an active-low coprocessor-ready test input. It passes each one through a two-flop synchronizer before any logic looks at it.

The block qualifies the reset request by width. A synchronized pulse shorter than four clocks is discarded. A longer one holds the core in reset for as long as the pin stays high. On release, the block issues a one-cycle restart strobe together with the restart fetch offset FFF0h.

The non-maskable request is captured on its rising edge and held pending until the core acknowledges it. The maskable request is looked at only when the core signals the end of an instruction. At each such boundary the block registers a decision for the core: continue, take the non-maskable interrupt (type 2), or start an interrupt acknowledge sequence. While the core executes a WAIT instruction, a separate combinational output tells it whether to stall.

Top module: `irq_front_end`

## Requirements
- R1: While the block reset `rst` is high, on the next clock `core_hold`, `restart_pulse` and `act_valid` are 0, `act_kind` is 0 and the NMI pending state is cleared.
- R2: If the synchronized reset pin stays high for at least 4 consecutive clocks, `core_hold` rises. A raw pin that goes high before clock edge 1 and stays high gives `core_hold` = 1 after edge 6. `core_hold` then stays 1 while the synchronized pin stays high.
- R3: A synchronized reset pulse of 3 clocks or fewer never asserts `core_hold`.
- R4: On the clock where a held reset is released, `core_hold` falls and `restart_pulse` is 1 for exactly one cycle. `restart_offset` always reads 16'hFFF0.
- R5: A qualified reset (`core_hold` = 1) clears any pending non-maskable event.
- R6: A rising edge of the synchronized non-maskable input sets a pending flag. A level that stays high does not set it again. At a boundary where the flag is already set, the decision is `act_kind` = 2'd1 (NMI) with `act_vector` = 2, whatever the value of `if_flag`.
- R7: When an NMI is pending and an enabled maskable request is present at the same boundary, the NMI decision wins.
- R8: `nmi_ack` clears the pending flag on the next clock. A rising edge seen in the same cycle as `nmi_ack` stays pending.
- R9: The maskable request is sampled only when `instr_end` = 1. If the synchronized request is high and `if_flag` = 1 (and no NMI is pending), the decision is `act_kind` = 2'd2 (interrupt acknowledge) with `act_vector` = 0. `act_valid` is 1 only in the cycle after an `instr_end` strobe.
- R10: With `if_flag` = 0 the maskable request is ignored, and the boundary decision is `act_kind` = 2'd0 (continue).
- R11: `wait_stall` = 1 exactly when `wait_active` = 1, the synchronized `pin_test_n` is 1 and `core_hold` = 0.
- R12: An `instr_end` strobe that arrives while `core_hold` = 1 produces no decision (`act_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| pin_reset | input | 1 | Asynchronous reset request pin, active high |
| pin_intr | input | 1 | Asynchronous maskable interrupt request, level, active high |
| pin_nmi | input | 1 | Asynchronous non-maskable interrupt request, rising edge |
| pin_test_n | input | 1 | Asynchronous coprocessor test input, active low |
| instr_end | input | 1 | Core strobe: last clock of the current instruction |
| if_flag | input | 1 | Core interrupt-enable flag |
| wait_active | input | 1 | Core is executing a WAIT instruction |
| nmi_ack | input | 1 | Core has accepted the pending NMI |
| core_hold | output | 1 | Qualified reset to the core |
| restart_pulse | output | 1 | One-cycle strobe on reset release |
| restart_offset | output | 16 | Fetch offset for restart (FFF0h) |
| act_valid | output | 1 | Boundary decision valid |
| act_kind | output | 2 | Decision: 0 continue, 1 NMI, 2 interrupt acknowledge |
| act_vector | output | 8 | Interrupt type for NMI decisions (2), else 0 |
| wait_stall | output | 1 | WAIT instruction must stall |

## Verification
The reset pin is driven with pulses of 2, 3, 4 and 10 raw clocks. These separate the discard and qualify cases exactly at the width limit and confirm that the restart strobe lasts one cycle. The interrupt inputs are tried in turn: NMI alone, the maskable request with the enable flag set and clear, both together, an NMI level held through an acknowledge, and an NMI pending across a qualified reset. Together these tell apart priority, masking, edge versus level capture and clearing. A long random phase then mixes all inputs, so that acknowledges landing on edges and boundaries landing during hold are compared against the behavioural model.

// File: rtl/ife_pkg.sv
package ife_pkg;

    typedef enum logic [1:0] {
        ACT_CONT = 2'd0,
        ACT_NMI  = 2'd1,
        ACT_INTA = 2'd2
    } act_e;

    typedef struct packed {
        logic       valid;
        act_e       kind;
        logic [7:0] vector;
    } decision_t;

    localparam logic [7:0] NMI_TYPE = 8'd2;

    // Boundary decision: a pending NMI beats an enabled maskable request.
    function automatic decision_t choose(input logic strobe,
                                         input logic nmi_pend,
                                         input logic intr_lvl,
                                         input logic ien);
        decision_t d;
        d.valid  = strobe;
        d.kind   = ACT_CONT;
        d.vector = 8'd0;
        if (strobe) begin
            if (nmi_pend) begin
                d.kind   = ACT_NMI;
                d.vector = NMI_TYPE;
            end else if (intr_lvl && ien) begin
                d.kind = ACT_INTA;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ife_sync.sv
module ife_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ife_reset_qual.sv
module ife_reset_qual #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic hold,
    output logic restart
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            hold    <= 1'b0;
            restart <= 1'b0;
        end else begin
            if (!pin_s)
                run_q <= '0;
            else if (run_q != LAST)
                run_q <= run_q + 1'b1;
            hold    <= pin_s && (run_q == LAST);
            restart <= hold && !pin_s;
        end
    end
endmodule

// File: rtl/ife_nmi_latch.sv
module ife_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_s,
    input  logic flush,
    input  logic ack,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = nmi_s && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_s;
            if (flush)      pend <= 1'b0;
            else if (rise)  pend <= 1'b1;
            else if (ack)   pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ife_decide.sv
module ife_decide
    import ife_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      hold,
    input  logic      nmi_pend,
    input  logic      intr_s,
    input  logic      ien,
    output decision_t dec
);
    decision_t nxt;

    always_comb nxt = choose(strobe && !hold, nmi_pend, intr_s, ien);

    always_ff @(posedge clk) begin
        if (rst) dec <= '0;
        else     dec <= nxt;
    end
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
    import ife_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          RST_MIN_CYC = 4,
    parameter logic [15:0] RESTART_OFS = 16'hFFF0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_reset,
    input  logic        pin_intr,
    input  logic        pin_nmi,
    input  logic        pin_test_n,
    input  logic        instr_end,
    input  logic        if_flag,
    input  logic        wait_active,
    input  logic        nmi_ack,
    output logic        core_hold,
    output logic        restart_pulse,
    output logic [15:0] restart_offset,
    output logic        act_valid,
    output logic [1:0]  act_kind,
    output logic [7:0]  act_vector,
    output logic        wait_stall
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] raw_pins;
    logic [NPIN-1:0] syn_pins;
    logic            rst_s, intr_s, nmi_s, test_s;
    logic            nmi_pend;
    decision_t       dec;

    assign raw_pins = {pin_test_n, pin_nmi, pin_intr, pin_reset};

    ife_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    assign rst_s  = syn_pins[0];
    assign intr_s = syn_pins[1];
    assign nmi_s  = syn_pins[2];
    assign test_s = syn_pins[3];

    ife_reset_qual #(.MIN_CYC(RST_MIN_CYC)) u_rq (
        .clk     (clk),
        .rst     (rst),
        .pin_s   (rst_s),
        .hold    (core_hold),
        .restart (restart_pulse)
    );

    ife_nmi_latch u_nmi (
        .clk   (clk),
        .rst   (rst),
        .nmi_s (nmi_s),
        .flush (core_hold),
        .ack   (nmi_ack),
        .pend  (nmi_pend)
    );

    ife_decide u_dec (
        .clk      (clk),
        .rst      (rst),
        .strobe   (instr_end),
        .hold     (core_hold),
        .nmi_pend (nmi_pend),
        .intr_s   (intr_s),
        .ien      (if_flag),
        .dec      (dec)
    );

    assign restart_offset = RESTART_OFS;
    assign act_valid      = dec.valid;
    assign act_kind       = dec.kind;
    assign act_vector     = dec.vector;
    assign wait_stall     = wait_active && test_s && !core_hold;
endmodule

// File: rtl/irq_front_end_chk.sv
module irq_front_end_chk (
    input logic       clk,
    input logic       rst,
    input logic       instr_end,
    input logic       if_flag,
    input logic       wait_active,
    input logic       core_hold,
    input logic       restart_pulse,
    input logic       act_valid,
    input logic [1:0] act_kind,
    input logic [7:0] act_vector,
    input logic       wait_stall
);
    // R4: a restart strobe only follows a cycle of held reset
    a_r4_restart_after_hold: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |-> ($past(core_hold) && !core_hold));

    // R4: the strobe lasts a single cycle
    a_r4_restart_single: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |=> !restart_pulse);

    // R9: a decision appears only after an end-of-instruction strobe
    a_r9_act_after_strobe: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> $past(instr_end));

    // R12: no decision from a strobe seen during hold
    a_r12_no_act_in_hold: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> !$past(core_hold));

    // R6: NMI decisions carry type 2
    a_r6_nmi_vector: assert property (@(posedge clk) disable iff (rst)
        (act_valid && act_kind == 2'd1) |-> (act_vector == 8'd2));

    // R10: masked request never yields an acknowledge
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !$past(if_flag)) |-> (act_kind != 2'd2));

    // R11: no stall outside WAIT or during hold
    a_r11_stall_gate: assert property (@(posedge clk) disable iff (rst)
        (!wait_active || core_hold) |-> !wait_stall);

    // R1: block reset empties the decision output
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!act_valid && !core_hold && !restart_pulse));
endmodule

bind irq_front_end irq_front_end_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_end     (instr_end),
    .if_flag       (if_flag),
    .wait_active   (wait_active),
    .core_hold     (core_hold),
    .restart_pulse (restart_pulse),
    .act_valid     (act_valid),
    .act_kind      (act_kind),
    .act_vector    (act_vector),
    .wait_stall    (wait_stall)
);

// File: tb/irq_front_end_tb.sv
`timescale 1ns/1ps
module irq_front_end_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_reset = 0, pin_intr = 0, pin_nmi = 0, pin_test_n = 0;
    logic        instr_end = 0, if_flag = 0, wait_active = 0, nmi_ack = 0;
    logic        core_hold, restart_pulse, act_valid, wait_stall;
    logic [15:0] restart_offset;
    logic [1:0]  act_kind;
    logic [7:0]  act_vector;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_front_end u_dut (
        .clk(clk), .rst(rst), .pin_reset(pin_reset), .pin_intr(pin_intr),
        .pin_nmi(pin_nmi), .pin_test_n(pin_test_n), .instr_end(instr_end),
        .if_flag(if_flag), .wait_active(wait_active), .nmi_ack(nmi_ack),
        .core_hold(core_hold), .restart_pulse(restart_pulse),
        .restart_offset(restart_offset), .act_valid(act_valid),
        .act_kind(act_kind), .act_vector(act_vector), .wait_stall(wait_stall)
    );

    // Behavioural reference: delayed pin copies, a run-length integer and flags.
    bit  pipe_a [4];
    bit  pipe_b [4];
    int  high_run;
    bit  m_hold, m_restart, m_pend, m_nmi_seen;
    bit  m_valid;
    int  m_kind, m_vec;

    task automatic model_step();
        bit cur_hold, cur_pend, rise;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin pipe_a[i] = 0; pipe_b[i] = 0; end
            high_run = 0; m_hold = 0; m_restart = 0; m_pend = 0;
            m_nmi_seen = 0; m_valid = 0; m_kind = 0; m_vec = 0;
        end else begin
            cur_hold = m_hold;
            cur_pend = m_pend;
            high_run = pipe_b[0] ? high_run + 1 : 0;
            if (high_run > 1000) high_run = 1000;
            m_hold    = pipe_b[0] && (high_run >= 4);
            m_restart = cur_hold && !pipe_b[0];
            rise = pipe_b[2] && !m_nmi_seen;
            m_nmi_seen = pipe_b[2];
            if (cur_hold)     m_pend = 0;
            else if (rise)    m_pend = 1;
            else if (nmi_ack) m_pend = 0;
            m_valid = instr_end && !cur_hold;
            m_kind = 0; m_vec = 0;
            if (m_valid) begin
                if (cur_pend) begin m_kind = 1; m_vec = 2; end
                else if (pipe_b[1] && if_flag) m_kind = 2;
            end
            for (int i = 0; i < 4; i++) pipe_b[i] = pipe_a[i];
            pipe_a[0] = pin_reset; pipe_a[1] = pin_intr;
            pipe_a[2] = pin_nmi;   pipe_a[3] = pin_test_n;
        end
    endtask

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_stall;
        vectors++;
        exp_stall = wait_active && pipe_b[3] && !m_hold;
        cmp("R2/R3 core_hold", int'(core_hold), int'(m_hold));
        cmp("R4 restart_pulse", int'(restart_pulse), int'(m_restart));
        cmp("R4 restart_offset", int'(restart_offset), 16'hFFF0);
        cmp("R9/R12 act_valid", int'(act_valid), int'(m_valid));
        cmp("R6/R7/R8/R10 act_kind", int'(act_kind), m_kind);
        cmp("R6 act_vector", int'(act_vector), m_vec);
        cmp("R11 wait_stall", int'(wait_stall), int'(exp_stall));
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            #2;
            compare_all();
            instr_end = 0;
            nmi_ack   = 0;
        end
    endtask

    task automatic rst_pulse(input int len);
        pin_reset = 1; cyc(len);
        pin_reset = 0; cyc(8);
    endtask

    task automatic boundary();
        instr_end = 1; cyc(1); cyc(1);
    endtask

    initial begin
        // R1: block reset state
        cyc(3);
        rst = 0;
        cyc(2);

        // R3: short pulses discarded; R2/R4: width limit and longer pulse
        rst_pulse(2);
        rst_pulse(3);
        rst_pulse(4);
        rst_pulse(10);

        // R6: NMI edge then boundary, with enable off
        if_flag = 0;
        pin_nmi = 1; cyc(4);
        boundary();
        // R8: acknowledge clears; held level does not retrigger
        nmi_ack = 1; cyc(1);
        boundary();
        pin_nmi = 0; cyc(3);

        // R9: maskable request enabled; R10: masked
        pin_intr = 1; cyc(3);
        if_flag = 1; boundary();
        if_flag = 0; boundary();
        cyc(2);

        // R7: NMI and enabled request together
        if_flag = 1;
        pin_nmi = 1; cyc(4);
        boundary();
        nmi_ack = 1; cyc(1);
        pin_nmi = 0; pin_intr = 0; cyc(3);

        // R5: pending NMI wiped by qualified reset; R12: strobe during hold
        pin_nmi = 1; cyc(4); pin_nmi = 0;
        pin_reset = 1; cyc(7);
        instr_end = 1; cyc(1);
        pin_reset = 0; cyc(6);
        boundary();

        // R8: acknowledge in the same cycle as a new edge
        pin_nmi = 1; cyc(2); nmi_ack = 1; cyc(1); cyc(2);
        boundary();
        nmi_ack = 1; cyc(1); pin_nmi = 0; cyc(2);

        // R11: WAIT stall follows test input
        wait_active = 1;
        pin_test_n = 1; cyc(4);
        pin_test_n = 0; cyc(4);
        wait_active = 0; pin_test_n = 1; cyc(3);

        // mixed random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) pin_reset = ~pin_reset;
            else if (pin_reset && r < 20) pin_reset = 0;
            pin_intr    = ($urandom_range(0, 3) != 0) ? pin_intr : ~pin_intr;
            pin_nmi     = ($urandom_range(0, 9) != 0) ? pin_nmi : ~pin_nmi;
            pin_test_n  = $urandom_range(0, 1);
            if_flag     = $urandom_range(0, 1);
            wait_active = $urandom_range(0, 1);
            instr_end   = ($urandom_range(0, 3) == 0);
            nmi_ack     = ($urandom_range(0, 4) == 0);
            cyc(1);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule